// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a small 8-bit controller core whose program space is 12 bits wide (10 or 11 bits by parameter). Each cycle it takes decoded strobes from the instruction decoder and picks the next address. The choices are the following address, a two-step advance when a test-and-skip condition holds, a direct jump or call built from a short immediate field plus page bits, a return taken from a hardware stack, or an indirect or relative jump made by writing W to the PC or adding W to it through the data-register path.

Every change of flow is followed by a one-cycle flush pulse to the fetch pipeline. A busy flag then covers the refill cycles, during which decoder strobes are ignored. A timing-mode input selects whether a change of flow costs two or three cycles in total. The return stack is circular. An overflow overwrites the oldest entry without comment, and a pop from an empty stack gives back the value of the previous pop.

Top module: `pc_sequencer`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, fetchAddr equals RESET_VEC (0 by default), and flush and busy are 0.
- R2: In an accepting cycle (busy low) with no strobe active, or with opSkip active and skipCond low, the next fetchAddr is the current one plus 1 modulo 2^AW, with no flush.
- R3: opJump loads {pageSel[AW-10:0], immAddr[8:0]}, with immAddr in bits 8..0.
- R4: opCall loads {pageSel[AW-10:0], 1'b0, immAddr[7:0]} and pushes the current fetchAddr plus 1.
- R5: opRet loads the most recently pushed address that has not yet been popped, so nested calls return in last-in first-out order.
- R6: The stack holds STACK_DEPTH entries. A push onto a full stack overwrites the oldest entry, so the next STACK_DEPTH pops return the newest STACK_DEPTH addresses. A pop from an empty stack returns the value of the previous pop (0 if there was none).
- R7: opPcWrite loads {pageSel[AW-10:0], 1'b0, wData}.
- R8: opPcAdd loads {pageSel[AW-10:0], 1'b0, S}, where S is the low 8 bits of (fetchAddr + 1) plus wData, modulo 256.
- R9: opSkip with skipCond high advances fetchAddr by 2 and counts as a change of flow.
- R10: A change of flow (jump, call, return, PC write, PC add, taken skip) raises flush for exactly the next cycle. busy is high for 1 cycle after the change when turboMode was 0 at acceptance, and for 2 cycles when it was 1.
- R11: While busy is high, all strobes are ignored and fetchAddr holds.
- R12: When several strobes are active together, one acts, in this order of precedence: opCall, opJump, opRet, opPcWrite, opPcAdd, opSkip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| turboMode | input | 1 | 1: flow change costs 3 cycles; 0: 2 cycles |
| opJump | input | 1 | Direct jump strobe |
| opCall | input | 1 | Subroutine call strobe |
| opRet | input | 1 | Return strobe |
| opPcWrite | input | 1 | W written to the PC register |
| opPcAdd | input | 1 | W added to the PC register |
| opSkip | input | 1 | Test-and-skip instruction strobe |
| skipCond | input | 1 | Result of the skip test |
| immAddr | input | 9 | Address field from the instruction |
| wData | input | 8 | W register value |
| pageSel | input | 3 | Page-select bits |
| fetchAddr | output | AW | Current fetch address |
| flush | output | 1 | Pipeline flush pulse |
| busy | output | 1 | Refill in progress, strobes ignored |

## Verification
The bench builds the block with AW at 12 and STACK_DEPTH lowered to 4. The reduced depth puts stack overflow and the pop-from-empty case within five nested calls. The full 12-bit width lets all three page bits reach the address, and a jump to the top address shows the wrap to zero. Both timing modes are exercised, and strobes are presented while busy is high.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    SEL_HOLD, SEL_INC, SEL_SKIP, SEL_JUMP,
    SEL_CALL, SEL_RET, SEL_WRITE, SEL_ADD
  } nextSel_e;

  typedef struct packed {
    nextSel_e sel;
    logic     push;
    logic     pop;
  } pcCtl_t;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
  import pcseq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   turboMode,
  input  logic   opJump,
  input  logic   opCall,
  input  logic   opRet,
  input  logic   opPcWrite,
  input  logic   opPcAdd,
  input  logic   opSkip,
  input  logic   skipCond,
  output pcCtl_t ctl,
  output logic   busy,
  output logic   flush
);
  logic [1:0] waitCnt;
  logic       flushQ;
  logic       flowChg;

  assign busy  = (waitCnt != 2'd0);
  assign flush = flushQ;

  always_comb begin
    ctl = '{sel: SEL_INC, push: 1'b0, pop: 1'b0};
    if (busy)                 ctl.sel = SEL_HOLD;
    else if (opCall)          begin ctl.sel = SEL_CALL; ctl.push = 1'b1; end
    else if (opJump)          ctl.sel = SEL_JUMP;
    else if (opRet)           begin ctl.sel = SEL_RET; ctl.pop = 1'b1; end
    else if (opPcWrite)       ctl.sel = SEL_WRITE;
    else if (opPcAdd)         ctl.sel = SEL_ADD;
    else if (opSkip && skipCond) ctl.sel = SEL_SKIP;
  end

  assign flowChg = (ctl.sel != SEL_INC) && (ctl.sel != SEL_HOLD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= 2'd0;
      flushQ  <= 1'b0;
    end else if (flowChg) begin
      waitCnt <= turboMode ? 2'd2 : 2'd1;
      flushQ  <= 1'b1;
    end else begin
      if (busy) waitCnt <= waitCnt - 2'd1;
      flushQ <= 1'b0;
    end
  end
endmodule

// File: rtl/pcseq_datapath.sv
module pcseq_datapath
  import pcseq_pkg::*;
#(
  parameter int          AW          = 12,
  parameter int          STACK_DEPTH = 8,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  pcCtl_t        ctl,
  input  logic [8:0]    immAddr,
  input  logic [7:0]    wData,
  input  logic [2:0]    pageSel,
  output logic [AW-1:0] fetchAddr
);
  localparam int PB = AW - 9;
  localparam int PW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [AW-1:0] pc, incAddr, nextPc, popVal, lastPop;
  logic [AW-1:0] stackMem [STACK_DEPTH];
  logic [PW-1:0] wrPtr, rdIdx;
  logic [CW-1:0] fill;
  logic [PB-1:0] page;
  logic [7:0]    relLow;

  assign page    = pageSel[PB-1:0];
  assign incAddr = pc + AW'(1);
  assign relLow  = incAddr[7:0] + wData;
  assign rdIdx   = wrPtr - PW'(1);
  assign popVal  = (fill != '0) ? stackMem[rdIdx] : lastPop;
  assign fetchAddr = pc;

  always_comb begin
    unique case (ctl.sel)
      SEL_HOLD:  nextPc = pc;
      SEL_INC:   nextPc = incAddr;
      SEL_SKIP:  nextPc = pc + AW'(2);
      SEL_JUMP:  nextPc = {page, immAddr};
      SEL_CALL:  nextPc = {page, 1'b0, immAddr[7:0]};
      SEL_RET:   nextPc = popVal;
      SEL_WRITE: nextPc = {page, 1'b0, wData};
      SEL_ADD:   nextPc = {page, 1'b0, relLow};
      default:   nextPc = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= RESET_VEC;
      wrPtr   <= '0;
      fill    <= '0;
      lastPop <= '0;
    end else begin
      pc <= nextPc;
      if (ctl.push) begin
        wrPtr <= wrPtr + PW'(1);
        if (fill != CW'(STACK_DEPTH)) fill <= fill + CW'(1);
      end else if (ctl.pop) begin
        lastPop <= popVal;
        if (fill != '0) begin
          wrPtr <= rdIdx;
          fill  <= fill - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && ctl.push) stackMem[wrPtr] <= incAddr;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int            AW          = 12,
  parameter int            STACK_DEPTH = 8,
  parameter logic [AW-1:0] RESET_VEC   = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          turboMode,
  input  logic          opJump,
  input  logic          opCall,
  input  logic          opRet,
  input  logic          opPcWrite,
  input  logic          opPcAdd,
  input  logic          opSkip,
  input  logic          skipCond,
  input  logic [8:0]    immAddr,
  input  logic [7:0]    wData,
  input  logic [2:0]    pageSel,
  output logic [AW-1:0] fetchAddr,
  output logic          flush,
  output logic          busy
);
  pcCtl_t ctl;

  pcseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .turboMode(turboMode),
    .opJump(opJump), .opCall(opCall), .opRet(opRet),
    .opPcWrite(opPcWrite), .opPcAdd(opPcAdd),
    .opSkip(opSkip), .skipCond(skipCond),
    .ctl(ctl), .busy(busy), .flush(flush)
  );

  pcseq_datapath #(.AW(AW), .STACK_DEPTH(STACK_DEPTH), .RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .immAddr(immAddr),
    .wData(wData), .pageSel(pageSel), .fetchAddr(fetchAddr)
  );
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rstN,
  input logic          opJump,
  input logic          opCall,
  input logic          opRet,
  input logic          opPcWrite,
  input logic          opPcAdd,
  input logic          opSkip,
  input logic          skipCond,
  input logic [8:0]    immAddr,
  input logic [AW-1:0] fetchAddr,
  input logic          flush,
  input logic          busy
);
  logic anyOp, flowOp;
  assign anyOp  = opJump | opCall | opRet | opPcWrite | opPcAdd | opSkip;
  assign flowOp = opJump | opCall | opRet | opPcWrite | opPcAdd | (opSkip & skipCond);

  // R2: a plain cycle steps the address by one without flushing
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyOp) |=> (fetchAddr == AW'($past(fetchAddr) + AW'(1))) && !flush);

  // R3: the low nine bits of a jump target come from the immediate field
  p_jump_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opJump && !opCall) |=> fetchAddr[8:0] == $past(immAddr));

  // R10: a change of flow raises flush in the next cycle
  p_flow_flush_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flowOp) |=> flush && busy);

  // R10: flush lasts one cycle only
  p_flush_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !flush);

  // R11: the address holds while busy
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(fetchAddr));
endmodule

bind pc_sequencer pcseq_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .opJump(opJump), .opCall(opCall), .opRet(opRet),
  .opPcWrite(opPcWrite), .opPcAdd(opPcAdd), .opSkip(opSkip),
  .skipCond(skipCond), .immAddr(immAddr), .fetchAddr(fetchAddr),
  .flush(flush), .busy(busy)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
  localparam int AW = 12;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic turboMode = 1'b0;
  logic opJump = 0, opCall = 0, opRet = 0, opPcWrite = 0, opPcAdd = 0, opSkip = 0, skipCond = 0;
  logic [8:0] immAddr = '0;
  logic [7:0] wData = '0;
  logic [2:0] pageSel = '0;
  logic [AW-1:0] fetchAddr;
  logic flush, busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pc_sequencer #(.AW(AW), .STACK_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .turboMode(turboMode), .opJump(opJump),
    .opCall(opCall), .opRet(opRet), .opPcWrite(opPcWrite), .opPcAdd(opPcAdd),
    .opSkip(opSkip), .skipCond(skipCond), .immAddr(immAddr), .wData(wData),
    .pageSel(pageSel), .fetchAddr(fetchAddr), .flush(flush), .busy(busy)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  task automatic clearOps();
    opJump = 0; opCall = 0; opRet = 0; opPcWrite = 0; opPcAdd = 0; opSkip = 0; skipCond = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // strobes are already set by the caller; hold for one edge, then clear
  task automatic fire();
    @(negedge clk);
    clearOps();
  endtask

  task automatic doJump(input logic [2:0] pg, input logic [8:0] imm);
    waitIdle(); pageSel = pg; immAddr = imm; opJump = 1; fire();
  endtask

  task automatic doCall(input logic [2:0] pg, input logic [7:0] imm);
    waitIdle(); pageSel = pg; immAddr = {1'b0, imm}; opCall = 1; fire();
  endtask

  task automatic doRet();
    waitIdle(); opRet = 1; fire();
  endtask

  task automatic testReset();
    check("R1 addr", fetchAddr, 0);
    check("R1 flush", flush, 0);
    check("R1 busy", busy, 0);
  endtask

  task automatic testSequential();
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R2 step", fetchAddr, 3);
    check("R2 noflush", flush, 0);
    doJump(3'd7, 9'h1FF);
    check("R3 top", fetchAddr, 12'hFFF);
    waitIdle(); @(negedge clk);
    check("R2 wrap", fetchAddr, 0);
  endtask

  task automatic testJumpTiming();
    turboMode = 0;
    doJump(3'd5, 9'h123);
    check("R3 target", fetchAddr, 12'hB23);
    check("R10 flush", flush, 1);
    check("R10 busy1", busy, 1);
    @(negedge clk);
    check("R10 compat done", busy, 0);
    check("R10 flush low", flush, 0);
    turboMode = 1;
    doJump(3'd1, 9'h010);
    check("R3 target2", fetchAddr, 12'h210);
    check("R10 turbo flush", flush, 1);
    @(negedge clk);
    check("R10 turbo busy2", busy, 1);
    check("R10 turbo flush2", flush, 0);
    @(negedge clk);
    check("R10 turbo done", busy, 0);
    turboMode = 0;
  endtask

  task automatic testCallRet();
    int base;
    base = fetchAddr;
    doCall(3'd3, 8'h45);
    check("R4 call", fetchAddr, 12'h645);
    doCall(3'd1, 8'hF0);
    check("R4 call2", fetchAddr, 12'h2F0);
    doRet();
    check("R5 ret inner", fetchAddr, 12'h646);
    doRet();
    check("R5 ret outer", fetchAddr, base + 1);
  endtask

  task automatic testOverflow();
    int ra [5];
    for (int i = 0; i < 5; i++) begin
      waitIdle();
      ra[i] = fetchAddr + 1;
      doCall(3'(i), 8'(8'h10 * i + 3));
      check("R4 ovf call", fetchAddr, (i << 9) | (16 * i + 3));
    end
    for (int i = 4; i >= 1; i--) begin
      doRet();
      check("R6 ovf pop", fetchAddr, ra[i]);
    end
    doRet();
    check("R6 underflow", fetchAddr, ra[1]);
  endtask

  task automatic testPcWriteAdd();
    waitIdle(); pageSel = 3'd2; wData = 8'h5A; opPcWrite = 1; fire();
    check("R7 write", fetchAddr, 12'h45A);
    waitIdle(); pageSel = 3'd6; wData = 8'hEF; opPcWrite = 1; fire();
    check("R7 write2", fetchAddr, 12'hCEF);
    waitIdle(); pageSel = 3'd4; wData = 8'h20; opPcAdd = 1; fire();
    check("R8 add wrap", fetchAddr, 12'h810);
    check("R10 add flush", flush, 1);
    waitIdle(); pageSel = 3'd4; wData = 8'h05; opPcAdd = 1; fire();
    check("R8 add", fetchAddr, 12'h816);
  endtask

  task automatic testSkip();
    int a;
    waitIdle(); a = fetchAddr;
    opSkip = 1; skipCond = 0; fire();
    check("R2 skip not taken", fetchAddr, a + 1);
    check("R2 skip nt noflush", flush, 0);
    opSkip = 1; skipCond = 1; fire();
    check("R9 skip taken", fetchAddr, a + 3);
    check("R9 skip flush", flush, 1);
    waitIdle();
  endtask

  task automatic testBusyIgnore();
    turboMode = 1;
    doJump(3'd0, 9'h0AA);
    pageSel = 3'd7; immAddr = 9'h155; opJump = 1; opCall = 1;
    @(negedge clk);
    check("R11 hold1", fetchAddr, 12'h0AA);
    @(negedge clk);
    clearOps();
    check("R11 hold2", fetchAddr, 12'h0AA);
    check("R11 idle", busy, 0);
    @(negedge clk);
    check("R11 resume", fetchAddr, 12'h0AB);
    turboMode = 0;
  endtask

  task automatic testPriority();
    int a;
    waitIdle(); a = fetchAddr;
    pageSel = 3'd1; immAddr = 9'h1C4; opCall = 1; opJump = 1; opRet = 1; fire();
    check("R12 call wins", fetchAddr, 12'h2C4);
    waitIdle();
    pageSel = 3'd3; immAddr = 9'h1E0; opJump = 1; opRet = 1; opPcWrite = 1; fire();
    check("R12 jump wins", fetchAddr, 12'h7E0);
    waitIdle();
    opRet = 1; opPcWrite = 1; opSkip = 1; skipCond = 1; fire();
    check("R12 ret wins", fetchAddr, a + 1);
    waitIdle();
    pageSel = 3'd5; wData = 8'h33; opPcWrite = 1; opPcAdd = 1; opSkip = 1; skipCond = 1; fire();
    check("R12 write wins", fetchAddr, 12'hA33);
    waitIdle();
    pageSel = 3'd5; wData = 8'h01; opPcAdd = 1; opSkip = 1; skipCond = 1; fire();
    check("R12 add wins", fetchAddr, 12'hA35);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", fetchAddr, 0);
    rstN = 1;
    testReset();
    testSequential();
    testJumpTiming();
    testCallRet();
    testOverflow();
    testPcWriteAdd();
    testSkip();
    testBusyIgnore();
    testPriority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule